// File: doc/BRIEF.md
# Delayed Branch Next-PC Sequencer

This block produces the fetch address for a scalar, in-order fetch stage whose instruction set has architectural branch delay slots. Each cycle the decoder tells it whether the instruction now being fetched is a branch. For a branch it also supplies a 4-bit condition code, an annul flag and a target address. The current integer flags N, Z, V and C arrive as plain inputs. The sequencer keeps a fetch-address register and a following-address register. A control transfer therefore takes effect one instruction late: the instruction right after a branch always issues before fetch reaches the target.

The annul flag lets the branch cancel its delay-slot instruction. With annul set, the slot is squashed when a conditional branch falls through. It is also squashed on every branch-always and every branch-never. A squashed slot still occupies its fetch cycle, and `slotSquash` is high during that cycle so that later stages drop it. The sequencer also ignores any branch decoded from a squashed slot. A branch that sits in a live delay slot gets no special treatment and simply follows the register-pair rule.

Top module: `delayed_branch_seq`

## Requirements
- R1: While `rstN` is low, `fetchPc` is 0 and `slotSquash` is 0. After release, the first fetch addresses are 0 and then 4.
- R2: In any cycle without an honoured branch, the address two cycles later equals the address one cycle later plus 4. An honoured branch is one with `brValid` high and `slotSquash` low.
- R3: A taken branch honoured while `fetchPc` is P gives `fetchPc` = P+4 in the next cycle (the delay slot) and `fetchPc` = `brTarget` in the cycle after that.
- R4: Condition code 4'b1000 (always) is taken for every combination of flags.
- R5: Condition code 4'b0000 (never) is not taken. Every code not listed in R4 or R6 is also not taken. Fetch continues sequentially after the delay slot.
- R6: The conditional codes are taken as follows, and not taken otherwise:
  - 4'b0001 (equal) when Z=1.
  - 4'b1001 (not equal) when Z=0.
  - 4'b0011 (less) when N xor V = 1.
  - 4'b1011 (greater-or-equal) when N xor V = 0.
  - 4'b0101 (carry set) when C=1.
  - 4'b1101 (carry clear) when C=0.
- R7: With `brAnnul` set on a conditional code, `slotSquash` is high in the delay-slot cycle when the branch is not taken, and low when it is taken.
- R8: With `brAnnul` set on code 4'b1000 or 4'b0000, `slotSquash` is high in the delay-slot cycle.
- R9: An honoured branch with `brAnnul` low never makes `slotSquash` high in the following cycle.
- R10: While `slotSquash` is high, the branch inputs are ignored. Fetch stays sequential and `slotSquash` is low in the next cycle.
- R11: A taken branch in a live delay slot redirects after its own slot. Branch at P to T, with a branch to U at P+4, fetches P, P+4, T, U, U+4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| brValid | input | 1 | Instruction at `fetchPc` is a branch |
| brCond | input | 4 | Condition code of the branch |
| brAnnul | input | 1 | Annul flag of the branch |
| brTarget | input | AddrW | Branch target address |
| flagN | input | 1 | Negative flag |
| flagZ | input | 1 | Zero flag |
| flagV | input | 1 | Overflow flag |
| flagC | input | 1 | Carry flag |
| fetchPc | output | AddrW | Address fetched this cycle |
| slotSquash | output | 1 | Instruction at `fetchPc` is an annulled delay slot |

## Verification
The properties assume three things about the decoder side. The branch inputs describe the instruction at the current `fetchPc` in the same cycle. They are never unknown while reset is released. The target is valid in the same cycle as `brValid`. The directed stimulus changes every input only on the falling clock edge. It drives zeros on the branch fields whenever no branch is presented and holds all inputs at idle during reset. Each scenario starts from a fresh reset, so every expected address is known from address 0 onward.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [3:0] CondNever  = 4'b0000;
  localparam logic [3:0] CondEq     = 4'b0001;
  localparam logic [3:0] CondLt     = 4'b0011;
  localparam logic [3:0] CondCs     = 4'b0101;
  localparam logic [3:0] CondAlways = 4'b1000;
  localparam logic [3:0] CondNe     = 4'b1001;
  localparam logic [3:0] CondGe     = 4'b1011;
  localparam logic [3:0] CondCc     = 4'b1101;

  typedef struct packed {
    logic takeTarget;  // next-address register loads the target
    logic killSlot;    // instruction fetched next cycle is annulled
  } seqStrobe_t;
endpackage

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic       brValid,
  input  logic [3:0] brCond,
  input  logic       brAnnul,
  input  logic       flagN,
  input  logic       flagZ,
  input  logic       flagV,
  input  logic       flagC,
  input  logic       squashNow,
  output seqStrobe_t strobe
);
  logic honoured;
  logic condTrue;
  logic isAlways;

  always_comb begin
    unique case (brCond)
      CondAlways: condTrue = 1'b1;
      CondEq:     condTrue = flagZ;
      CondNe:     condTrue = ~flagZ;
      CondLt:     condTrue = flagN ^ flagV;
      CondGe:     condTrue = ~(flagN ^ flagV);
      CondCs:     condTrue = flagC;
      CondCc:     condTrue = ~flagC;
      default:    condTrue = 1'b0;
    endcase
  end

  assign isAlways = (brCond == CondAlways);
  assign honoured = brValid & ~squashNow;

  always_comb begin
    strobe.takeTarget = honoured & condTrue;
    strobe.killSlot   = honoured & brAnnul & (isAlways | ~condTrue);
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int InsnBytes = 4,
  parameter int ResetPc   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [AddrW-1:0] brTarget,
  output logic [AddrW-1:0] pcQ,
  output logic             squashQ
);
  localparam logic [AddrW-1:0] StepVal  = AddrW'(InsnBytes);
  localparam logic [AddrW-1:0] PcInit   = AddrW'(ResetPc);
  localparam logic [AddrW-1:0] NextInit = PcInit + StepVal;

  logic [AddrW-1:0] nextQ;
  logic [AddrW-1:0] nextSeq;

  assign nextSeq = nextQ + StepVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= PcInit;
      nextQ   <= NextInit;
      squashQ <= 1'b0;
    end else begin
      pcQ     <= nextQ;
      nextQ   <= strobe.takeTarget ? brTarget : nextSeq;
      squashQ <= strobe.killSlot;
    end
  end
endmodule

// File: rtl/delayed_branch_seq.sv
module delayed_branch_seq
  import seq_pkg::*;
#(
  parameter int AddrW     = 32,
  parameter int InsnBytes = 4,
  parameter int ResetPc   = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             brValid,
  input  logic [3:0]       brCond,
  input  logic             brAnnul,
  input  logic [AddrW-1:0] brTarget,
  input  logic             flagN,
  input  logic             flagZ,
  input  logic             flagV,
  input  logic             flagC,
  output logic [AddrW-1:0] fetchPc,
  output logic             slotSquash
);
  seqStrobe_t strobe;
  logic       squashQ;

  seq_ctrl u_ctrl (
    .brValid  (brValid),
    .brCond   (brCond),
    .brAnnul  (brAnnul),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagV    (flagV),
    .flagC    (flagC),
    .squashNow(squashQ),
    .strobe   (strobe)
  );

  seq_datapath #(
    .AddrW    (AddrW),
    .InsnBytes(InsnBytes),
    .ResetPc  (ResetPc)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .brTarget(brTarget),
    .pcQ     (fetchPc),
    .squashQ (squashQ)
  );

  assign slotSquash = squashQ;
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int AddrW     = 32,
  parameter int InsnBytes = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             brValid,
  input logic [3:0]       brCond,
  input logic             brAnnul,
  input logic [AddrW-1:0] brTarget,
  input logic [AddrW-1:0] fetchPc,
  input logic             slotSquash
);
  localparam logic [AddrW-1:0] StepVal = AddrW'(InsnBytes);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rstN |-> (fetchPc == '0 && !slotSquash));

  // R2
  seq_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!brValid || slotSquash) |-> ##2 (fetchPc == $past(fetchPc, 1) + StepVal));

  // R4
  always_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !slotSquash && brCond == 4'b1000) |-> ##2 (fetchPc == $past(brTarget, 2)));

  // R8
  annul_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (brValid && !slotSquash && brAnnul && (brCond == 4'b1000 || brCond == 4'b0000)) |=> slotSquash);

  // R9
  no_annul_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(brValid && !slotSquash && brAnnul) |=> !slotSquash);

  // R10
  squash_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotSquash |=> !slotSquash);
endmodule

bind delayed_branch_seq seq_chk #(.AddrW(AddrW), .InsnBytes(InsnBytes)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .brValid   (brValid),
  .brCond    (brCond),
  .brAnnul   (brAnnul),
  .brTarget  (brTarget),
  .fetchPc   (fetchPc),
  .slotSquash(slotSquash)
);

// File: tb/sim_delayed_branch_seq.sv
`timescale 1ns/1ps
module sim_delayed_branch_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        brValid = 1'b0;
  logic [3:0]  brCond = 4'h0;
  logic        brAnnul = 1'b0;
  logic [31:0] brTarget = '0;
  logic        flagN = 1'b0, flagZ = 1'b0, flagV = 1'b0, flagC = 1'b0;
  logic [31:0] fetchPc;
  logic        slotSquash;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  delayed_branch_seq u0 (
    .clk(clk), .rstN(rstN), .brValid(brValid), .brCond(brCond), .brAnnul(brAnnul),
    .brTarget(brTarget), .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC),
    .fetchPc(fetchPc), .slotSquash(slotSquash)
  );

  task automatic checkNow(input logic [31:0] expPc, input logic expSq, input string tag);
    compared++;
    if (fetchPc !== expPc) begin
      mismatched++;
      $display("FAIL %s fetchPc actual=%h expected=%h", tag, fetchPc, expPc);
    end
    compared++;
    if (slotSquash !== expSq) begin
      mismatched++;
      $display("FAIL %s slotSquash actual=%b expected=%b", tag, slotSquash, expSq);
    end
  endtask

  // Check the current cycle, drive this cycle's branch inputs, move to the next cycle.
  task automatic step(input logic v, input logic [3:0] c, input logic a,
                      input logic [31:0] t, input logic [3:0] f,
                      input logic [31:0] expPc, input logic expSq, input string tag);
    checkNow(expPc, expSq, tag);
    brValid = v; brCond = c; brAnnul = a; brTarget = t;
    {flagN, flagZ, flagV, flagC} = f;
    @(negedge clk);
  endtask

  task automatic idle(input logic [31:0] expPc, input logic expSq, input string tag);
    step(1'b0, 4'h0, 1'b0, 32'h0, 4'h0, expPc, expSq, tag);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    brValid = 1'b0; brCond = 4'h0; brAnnul = 1'b0; brTarget = '0;
    {flagN, flagZ, flagV, flagC} = 4'h0;
    @(negedge clk);
    checkNow(32'h0, 1'b0, "R1 in reset");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    idle(32'h0, 1'b0, "R1 first");
    idle(32'h4, 1'b0, "R1 second");
  endtask

  task automatic testSequential();
    doReset();
    for (int i = 0; i < 6; i++) idle(32'(i * 4), 1'b0, "R2 sequential");
  endtask

  task automatic testAlways();
    doReset();
    idle(32'h0, 1'b0, "R4 pre");
    step(1'b1, 4'b1000, 1'b0, 32'h100, 4'b0101, 32'h4, 1'b0, "R4 branch");
    idle(32'h8, 1'b0, "R3 delay slot R9");
    idle(32'h100, 1'b0, "R3 target");
    idle(32'h104, 1'b0, "R2 after target");
  endtask

  task automatic testNever();
    doReset();
    step(1'b1, 4'b0000, 1'b0, 32'h100, 4'b1111, 32'h0, 1'b0, "R5 never");
    idle(32'h4, 1'b0, "R5 slot");
    step(1'b1, 4'b0111, 1'b0, 32'h200, 4'b1111, 32'h8, 1'b0, "R5 unlisted");
    idle(32'hC, 1'b0, "R5 unlisted slot");
    idle(32'h10, 1'b0, "R5 sequential");
  endtask

  task automatic condCase(input logic [3:0] c, input logic [3:0] f, input logic taken,
                          input string tag);
    doReset();
    step(1'b1, c, 1'b0, 32'h200, f, 32'h0, 1'b0, tag);
    idle(32'h4, 1'b0, tag);
    idle(taken ? 32'h200 : 32'h8, 1'b0, tag);
  endtask

  // flags packed as {N,Z,V,C}
  task automatic testConds();
    condCase(4'b0001, 4'b0100, 1'b1, "R6 eq taken");
    condCase(4'b0001, 4'b1011, 1'b0, "R6 eq not");
    condCase(4'b1001, 4'b0000, 1'b1, "R6 ne taken");
    condCase(4'b1001, 4'b0100, 1'b0, "R6 ne not");
    condCase(4'b0011, 4'b1000, 1'b1, "R6 lt taken");
    condCase(4'b0011, 4'b1010, 1'b0, "R6 lt not");
    condCase(4'b1011, 4'b1010, 1'b1, "R6 ge taken");
    condCase(4'b1011, 4'b0010, 1'b0, "R6 ge not");
    condCase(4'b0101, 4'b0001, 1'b1, "R6 cs taken");
    condCase(4'b0101, 4'b1110, 1'b0, "R6 cs not");
    condCase(4'b1101, 4'b1110, 1'b1, "R6 cc taken");
    condCase(4'b1101, 4'b0001, 1'b0, "R6 cc not");
  endtask

  task automatic testAnnulCond();
    doReset();
    step(1'b1, 4'b0001, 1'b1, 32'h300, 4'b0000, 32'h0, 1'b0, "R7 eq annul fallthrough");
    idle(32'h4, 1'b1, "R7 slot squashed");
    idle(32'h8, 1'b0, "R7 after squash");
    doReset();
    step(1'b1, 4'b0001, 1'b1, 32'h300, 4'b0100, 32'h0, 1'b0, "R7 eq annul taken");
    idle(32'h4, 1'b0, "R7 slot kept");
    idle(32'h300, 1'b0, "R7 target");
  endtask

  task automatic testAnnulFixed();
    doReset();
    step(1'b1, 4'b1000, 1'b1, 32'h500, 4'b0000, 32'h0, 1'b0, "R8 always annul");
    idle(32'h4, 1'b1, "R8 always slot squashed");
    idle(32'h500, 1'b0, "R8 always target");
    doReset();
    step(1'b1, 4'b0000, 1'b1, 32'h500, 4'b1111, 32'h0, 1'b0, "R8 never annul");
    idle(32'h4, 1'b1, "R8 never slot squashed");
    idle(32'h8, 1'b0, "R8 never sequential");
  endtask

  task automatic testNoAnnul();
    doReset();
    step(1'b1, 4'b0001, 1'b0, 32'h600, 4'b0000, 32'h0, 1'b0, "R9 cond not taken");
    idle(32'h4, 1'b0, "R9 slot kept");
    step(1'b1, 4'b0000, 1'b0, 32'h600, 4'b0000, 32'h8, 1'b0, "R9 never");
    idle(32'hC, 1'b0, "R9 never slot kept");
  endtask

  task automatic testIgnoreSquashed();
    doReset();
    step(1'b1, 4'b1000, 1'b1, 32'h300, 4'b0000, 32'h0, 1'b0, "R10 setup");
    step(1'b1, 4'b1000, 1'b1, 32'h400, 4'b0000, 32'h4, 1'b1, "R10 squashed branch");
    idle(32'h300, 1'b0, "R10 no squash after");
    idle(32'h304, 1'b0, "R10 no redirect");
  endtask

  task automatic testSlotBranch();
    doReset();
    step(1'b1, 4'b1000, 1'b0, 32'h100, 4'b0000, 32'h0, 1'b0, "R11 first branch");
    step(1'b1, 4'b1000, 1'b0, 32'h200, 4'b0000, 32'h4, 1'b0, "R11 branch in slot");
    idle(32'h100, 1'b0, "R11 first target");
    idle(32'h200, 1'b0, "R11 second target");
    idle(32'h204, 1'b0, "R11 sequential");
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSequential();
    testAlways();
    testNever();
    testConds();
    testAnnulCond();
    testAnnulFixed();
    testNoAnnul();
    testIgnoreSquashed();
    testSlotBranch();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule